// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block sits in the address path of a segmented memory unit. It receives the cached descriptor of the selected segment and one access request. The descriptor gives a 32-bit base, a 20-bit limit, a granularity flag, a big/default flag and the type bits. The request gives a 32-bit offset, a byte count and an access kind. The block decides whether the access is legal. If it is, the block forms the linear address as base plus offset.

Three rules decide legality. The limit is scaled to bytes or to 4 KB pages. Expand-down data segments use the inverted valid range. The type rules control who may read, write or fetch. A refused access returns a fault vector that tells a stack fault (12) apart from a general protection fault (13).

The result comes from one register stage. The answer to a request presented on one clock edge is visible at the outputs after that edge, and a new request may be presented on every cycle.

Top module: `seg_access_check`

## Requirements
- R1: With `gran`=0 the highest legal byte offset is `limit` itself, so offset `limit` passes and offset `limit`+1 faults.
- R2: With `gran`=1 the highest legal byte offset is `limit` shifted left by 12 with the low 12 bits set to one.
- R3: The last byte touched, offset plus (`size_m1`+1) minus 1, must also be legal. This sum is formed 33 bits wide, so an access that wraps past 0xFFFFFFFF faults.
- R4: When `is_code`=0 and `seg_ec`=1 (expand-down), an offset is legal only if it is strictly greater than the scaled limit. Offset equal to the limit faults, and a limit of 0 admits every offset from 1 up to the top.
- R5: For an expand-down segment the last byte must not exceed the top of the range. The top is 0xFFFFFFFF when `big`=1 and 0xFFFF when `big`=0.
- R6: The access kind is encoded on `kind` as 0=read, 1=write, 2=fetch and 3=reserved. A write (`kind`=1) to a code segment (`is_code`=1) always faults with vector 13, whether or not the segment is conforming.
- R7: A write to a data segment with `seg_wr`=0 (read-only) faults with vector 13. A read of the same segment passes.
- R8: A read (`kind`=0) of a code segment passes only when `seg_wr`=1 (readable). A fetch (`kind`=2) passes for any code segment and faults for any data segment. `kind`=3 always faults with vector 13.
- R9: A bounds violation faults with vector 12 when `is_stack`=1 and with vector 13 otherwise. A type violation takes priority and always gives 13.
- R10: On a legal access `lin_addr` equals base plus offset modulo 2^32 and `fault`=0. On a refused access `ok`=0 and `lin_addr`=0.
- R11: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_valid` is low during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| seg_base | input | 32 | Segment base address |
| seg_limit | input | 20 | Raw segment limit |
| gran | input | 1 | Limit counts 4 KB pages when 1 |
| big | input | 1 | Expand-down top is 0xFFFFFFFF when 1, else 0xFFFF |
| is_code | input | 1 | Segment is code (1) or data (0) |
| seg_ec | input | 1 | Data: expand-down; code: conforming |
| seg_wr | input | 1 | Data: writable; code: readable |
| is_stack | input | 1 | Access goes through the stack segment |
| offset | input | 32 | Byte offset into the segment |
| size_m1 | input | 2 | Access length in bytes minus one |
| kind | input | 2 | 0 read, 1 write, 2 fetch, 3 reserved |
| out_valid | output | 1 | Result present |
| ok | output | 1 | Access allowed |
| fault | output | 4 | 0, 12 (stack) or 13 (general protection) |
| lin_addr | output | 32 | Linear address, zero when refused |

## Verification
The bench probes each bound at exactly the limit and one byte beyond it. An off-by-one comparison then shows up as a wrong pass or fail on one side of the boundary.

Several cases target the page granularity scaling and the expand-down range. The checks include a multi-byte access that straddles the limit and one that wraps past 0xFFFFFFFF. A design that checked only the first byte, or used a 32-bit sum, would let these through with a bogus address.

The type rule cases separate readable from execute-only code and fetch from read. The stack/general split includes a stack access that breaks both a type rule and a bound. A design with the wrong priority would return 12 there instead of 13.

// File: rtl/seg_access_check.sv
module seg_access_check #(
  parameter int AW  = 32,
  parameter int LW  = 20,
  parameter int SZW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] seg_base,
  input  logic [LW-1:0] seg_limit,
  input  logic          gran,
  input  logic          big,
  input  logic          is_code,
  input  logic          seg_ec,
  input  logic          seg_wr,
  input  logic          is_stack,
  input  logic [AW-1:0] offset,
  input  logic [SZW-1:0] size_m1,
  input  logic [1:0]    kind,
  output logic          out_valid,
  output logic          ok,
  output logic [3:0]    fault,
  output logic [AW-1:0] lin_addr
);
  localparam int PGB = AW - LW;
  localparam int SMALL_TOP_W = 16;
  localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_FE = 2'd2;
  localparam logic [3:0] V_SS = 4'd12, V_GP = 4'd13;

  wire [AW-1:0] upper = gran ? {seg_limit, {PGB{1'b1}}} : {{PGB{1'b0}}, seg_limit};
  wire [AW:0]   last  = {1'b0, offset} + {{(AW+1-SZW){1'b0}}, size_m1};
  wire [AW:0]   top   = big ? {1'b0, {AW{1'b1}}}
                            : {{(AW+1-SMALL_TOP_W){1'b0}}, {SMALL_TOP_W{1'b1}}};
  wire          expdn = !is_code && seg_ec;

  wire in_bounds = expdn ? ((offset > upper) && (last <= top))
                         : (last <= {1'b0, upper});

  logic type_ok;
  always_comb begin
    case (kind)
      K_RD:    type_ok = !is_code || seg_wr;
      K_WR:    type_ok = !is_code && seg_wr;
      K_FE:    type_ok = is_code;
      default: type_ok = 1'b0;
    endcase
  end

  wire [3:0] fault_n = !type_ok   ? V_GP :
                       !in_bounds ? (is_stack ? V_SS : V_GP) : 4'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      ok        <= 1'b0;
      fault     <= 4'd0;
      lin_addr  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ok       <= (fault_n == 4'd0);
        fault    <= fault_n;
        lin_addr <= (fault_n == 4'd0) ? seg_base + offset : '0;
      end
    end
  end

  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid)) |-> out_valid);
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> !out_valid);
  a_r9_vector_set: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fault == 4'd0 || fault == V_SS || fault == V_GP));
  a_r10_ok_matches_fault: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (ok == (fault == 4'd0)));
  a_r10_lin_sum: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && ok) |-> lin_addr == $past(seg_base + offset));
  a_r6_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && $past(is_code) && $past(kind) == K_WR)
      |-> (!ok && fault == V_GP));
  a_r8_data_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(is_code) && $past(kind) == K_FE)
      |-> !ok);
endmodule

// File: tb/test_seg_access_check.sv
`timescale 1ns/1ps
module test_seg_access_check;
  logic clk = 0, rst_n = 0, in_valid = 0;
  logic [31:0] seg_base = 0, offset = 0;
  logic [19:0] seg_limit = 0;
  logic gran = 0, big = 0, is_code = 0, seg_ec = 0, seg_wr = 0, is_stack = 0;
  logic [1:0] size_m1 = 0, kind = 0;
  logic out_valid, ok;
  logic [3:0] fault;
  logic [31:0] lin_addr;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { string tag; logic ok; logic [3:0] f; logic [31:0] lin; } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  seg_access_check i_seg_access_check (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_base(seg_base),
    .seg_limit(seg_limit), .gran(gran), .big(big), .is_code(is_code),
    .seg_ec(seg_ec), .seg_wr(seg_wr), .is_stack(is_stack), .offset(offset),
    .size_m1(size_m1), .kind(kind), .out_valid(out_valid), .ok(ok),
    .fault(fault), .lin_addr(lin_addr));

  task automatic send(string tag, logic [31:0] b, logic [19:0] lim, logic g, logic db,
                      logic cd, logic ec, logic wr, logic stk, logic [31:0] off,
                      logic [1:0] sm1, logic [1:0] kd, logic [3:0] ef);
    exp_t e;
    @(negedge clk);
    seg_base = b; seg_limit = lim; gran = g; big = db; is_code = cd; seg_ec = ec;
    seg_wr = wr; is_stack = stk; offset = off; size_m1 = sm1; kind = kd; in_valid = 1;
    e.tag = tag; e.ok = (ef == 0); e.f = ef; e.lin = (ef == 0) ? b + off : 32'd0;
    q.push_back(e);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      exp_t e;
      checks++;
      if (q.size() == 0) begin
        failures++;
        $display("FAIL R11 unexpected result: out_valid=1 expected 0");
      end else begin
        e = q.pop_front();
        if (ok !== e.ok || fault !== e.f || lin_addr !== e.lin) begin
          failures++;
          $display("FAIL %s: got ok=%0b fault=%0d lin=%h expected ok=%0b fault=%0d lin=%h",
                   e.tag, ok, fault, lin_addr, e.ok, e.f, e.lin);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset: out_valid=%b expected 0", out_valid);
    end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      failures++;
      $display("FAIL R11 after reset: out_valid=%b expected 0", out_valid);
    end
    // args: tag base limit g big code ec wr stk offset sm1 kind expected_fault
    send("R1 at limit",      32'h1000, 20'h100, 0,0,0,0,1,0, 32'h100, 0, 0, 0);
    send("R1 beyond limit",  32'h1000, 20'h100, 0,0,0,0,1,0, 32'h101, 0, 0, 13);
    send("R2 page top",      32'h0,    20'h2,   1,0,0,0,1,0, 32'h2FFF, 0, 0, 0);
    send("R2 past page",     32'h0,    20'h2,   1,0,0,0,1,0, 32'h3000, 0, 0, 13);
    send("R3 last in",       32'h40,   20'h100, 0,0,0,0,1,0, 32'hFE, 1, 0, 0);
    send("R3 straddle",      32'h40,   20'h100, 0,0,0,0,1,0, 32'hFE, 3, 0, 13);
    send("R3 wrap",          32'h0,    20'hFFFFF,1,0,0,0,1,0, 32'hFFFFFFFE, 3, 0, 13);
    send("R3 top dword",     32'h0,    20'hFFFFF,1,0,0,0,1,0, 32'hFFFFFFFC, 3, 0, 0);
    idle(2);
    send("R4 equal limit",   32'h0,    20'hFF,  0,1,0,1,1,0, 32'hFF, 0, 0, 13);
    send("R4 above limit",   32'h500,  20'hFF,  0,1,0,1,1,0, 32'h100, 0, 1, 0);
    send("R4 zero limit 0",  32'h0,    20'h0,   0,1,0,1,1,0, 32'h0, 0, 0, 13);
    send("R4 zero limit 1",  32'h0,    20'h0,   0,1,0,1,1,0, 32'h1, 0, 0, 0);
    send("R5 big top",       32'h0,    20'h0,   0,1,0,1,1,0, 32'hFFFFFFFF, 0, 0, 0);
    send("R5 small top",     32'h0,    20'h10,  0,0,0,1,1,0, 32'hFFFF, 0, 0, 0);
    send("R5 small over",    32'h0,    20'h10,  0,0,0,1,1,0, 32'h10000, 0, 0, 13);
    send("R5 small straddle",32'h0,    20'h10,  0,0,0,1,1,0, 32'hFFFE, 3, 0, 13);
    send("R5 big ok",        32'h0,    20'h10,  0,1,0,1,1,0, 32'h10000, 0, 0, 0);
    send("R6 code write",    32'h0,    20'hFFF, 0,0,1,0,1,0, 32'h10, 0, 1, 13);
    send("R6 conf write",    32'h0,    20'hFFF, 0,0,1,1,1,0, 32'h10, 0, 1, 13);
    send("R7 ro write",      32'h0,    20'hFFF, 0,0,0,0,0,0, 32'h10, 0, 1, 13);
    send("R7 ro read",       32'h200,  20'hFFF, 0,0,0,0,0,0, 32'h10, 0, 0, 0);
    send("R8 xo read",       32'h0,    20'hFFF, 0,0,1,0,0,0, 32'h10, 0, 0, 13);
    send("R8 rd code read",  32'h80,   20'hFFF, 0,0,1,0,1,0, 32'h10, 1, 0, 0);
    send("R8 xo fetch",      32'h80,   20'hFFF, 0,0,1,0,0,0, 32'h10, 3, 2, 0);
    send("R8 data fetch",    32'h0,    20'hFFF, 0,0,0,0,1,0, 32'h10, 0, 2, 13);
    send("R8 kind3",         32'h0,    20'hFFF, 0,0,0,0,1,0, 32'h10, 0, 3, 13);
    send("R9 stack bound",   32'h0,    20'hFF,  0,1,0,1,1,1, 32'h80, 0, 1, 12);
    send("R9 stack normal",  32'h0,    20'hFF,  0,1,0,0,1,1, 32'h100, 0, 0, 12);
    send("R9 stack type",    32'h0,    20'hFF,  0,1,0,1,0,1, 32'h80, 0, 1, 13);
    send("R10 wrap sum",     32'hFFFF0000, 20'hFFFFF, 1,0,0,0,1,0, 32'h00020000, 0, 0, 0);
    idle(4);
    checks++;
    if (q.size() != 0) begin
      failures++;
      $display("FAIL R11 missing results: got %0d pending expected 0", q.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule